// File: doc/BRIEF.md
# Programmable Row Readout Sequencer

This block walks a pixel matrix of 128 rows in an order set by a small stored program instead of a fixed counter. Each program entry names one row and may carry an end marker. A program can leave out rows that are known to be bad, and it can list a row or a group of rows several times so that a region of interest is read more often within one frame. For each entry the sequencer raises that row's gate line for one strobe window, then the same row's clear line for one strobe window, and then moves on to the next entry.

There are two program banks, for example a full scan and a region-of-interest scan. Software selects the bank it wants on a request input. The sequencer only switches banks at the boundary between two passes, so a frame that is in progress is never cut short. The word-write load port fills the banks. Each stored entry is kept as a 13-bit codeword: an extended Hamming code over 8 data bits, with four check bits and one overall parity bit. A single flipped bit is corrected silently and reported on a sticky error flag. Two flipped bits in one entry stop the sequence with every output low, until the error is cleared through the load port.

Top module: `row_seq_top`

## Requirements
- R1: After reset, every gate and clear line is low, `corr_err_o` and `halt_o` are low, `active_bank_o` is 0, and nothing is driven while `run` stays low.
- R2: While running, the rows are visited in program order starting from entry 0. An entry whose end marker is set is the last one of the pass, and the entry at address DEPTH-1 also ends the pass. The next step then restarts at entry 0. Rows that are not listed are never driven, and repeated entries drive their row again.
- R3: For each entry, the gate line of the selected row is high for exactly STROBE cycles. The clear line of the same row is high for the next STROBE cycles, and exactly one cycle with all lines low separates that clear from the next gate.
- R4: At most one gate line and at most one clear line are high at any time, and a gate line and a clear line are never high together.
- R5: `bank_req` is taken only when a pass starts. A change made during a pass takes effect after the last entry of that pass, and `active_bank_o` shows the bank being executed.
- R6: A cycle with `ld_we` high stores an entry at (`ld_bank`, `ld_addr`). In `ld_data`, bits 6:0 are the row number and bit 7 is the end marker. The entry is encoded into a 13-bit codeword, and that codeword is XORed with `ld_flip` before it is stored.
- R7: A stored codeword with any one bit flipped gives the same row sequence as a clean one and sets `corr_err_o`. The flag stays high, even when the sequencer is idle, until `err_clr` is pulsed.
- R8: A stored codeword with any two bits flipped stops the sequence when that entry is fetched. `halt_o` then stays high with all gate and clear lines low until `err_clr`, which returns the sequencer to idle.
- R9: When `run` drops, the step in progress completes, including its clear window, and no further row is driven. The next start begins at entry 0 of the requested bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables sequencing |
| bank_req | input | 1 | Requested program bank |
| ld_we | input | 1 | Program entry write strobe |
| ld_bank | input | 1 | Bank written |
| ld_addr | input | 7 | Entry address written |
| ld_data | input | 8 | Bit 7 end marker, bits 6:0 row number |
| ld_flip | input | 13 | Bit mask XORed into the stored codeword |
| err_clr | input | 1 | Clears the error flag and leaves the halt state |
| gate_o | output | 128 | One gate line per row |
| clear_o | output | 128 | One clear line per row |
| active_bank_o | output | 1 | Bank being executed |
| corr_err_o | output | 1 | Sticky flag: a single-bit error was corrected |
| halt_o | output | 1 | Sequence stopped on an uncorrectable entry |

## Verification
The assertions check on every cycle that the gate and clear vectors are each one-hot or empty and never active together, and that a clear window always directly follows a gate window. They also check that the bank changes only at a pass boundary or from idle, that the correction flag holds until it is cleared, and that the halt state holds with quiet outputs. Only the bench scenarios can show the actual row order against the loaded program: skipped and repeated rows, wrap at the end marker, the exact strobe widths and gap, where a deferred bank switch lands, and the exhaustive sweeps over every single-bit and every two-bit corruption of a stored codeword.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_FETCH = 3'd1,
      S_GATE  = 3'd2,
      S_CLEAR = 3'd3,
      S_HALT  = 3'd4
   } seq_state_t;

   // number of Hamming check bits needed for dw data bits
   function automatic int ecc_par_bits(input int dw);
      for (int p = 1; p < 31; p++) begin
         if ((1 << p) >= dw + p + 1) return p;
      end
      return 31;
   endfunction

   // codeword position (>=1, not a power of two) carries a data bit
   function automatic bit is_data_pos(input int pos);
      return (pos >= 1) && ((pos & (pos - 1)) != 0);
   endfunction

   // data bit index carried at a data position
   function automatic int data_idx(input int pos);
      int n;
      n = 0;
      for (int j = 1; j < pos; j++) begin
         if (is_data_pos(j)) n++;
      end
      return n;
   endfunction

   // positions covered by the check bit at power-of-two position chk
   function automatic logic [63:0] cover_mask(input int chk);
      logic [63:0] m;
      m = '0;
      for (int j = 1; j < 64; j++) begin
         if ((j & chk) != 0) m[j] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/rsq_ecc_enc.sv
module rsq_ecc_enc
   import rsq_pkg::*;
#(
   parameter int DW = 8,
   localparam int PW = ecc_par_bits(DW),
   localparam int CW = DW + PW + 1
) (
   input  logic [DW-1:0] data_i,
   output logic [CW-1:0] code_o
);

   logic [CW-1:1] base;
   logic [CW-1:1] code_hi;

   for (genvar i = 1; i < CW; i++) begin : g_pos
      if (is_data_pos(i)) begin : g_data
         assign base[i]    = data_i[data_idx(i)];
         assign code_hi[i] = base[i];
      end else begin : g_chk
         assign base[i]    = 1'b0;
         assign code_hi[i] = ^({base, 1'b0} & CW'(cover_mask(i)));
      end
   end

   // overall parity in position 0 turns the code into SECDED
   assign code_o = {code_hi, ^code_hi};

endmodule

// File: rtl/rsq_ecc_dec.sv
module rsq_ecc_dec
   import rsq_pkg::*;
#(
   parameter int DW = 8,
   localparam int PW = ecc_par_bits(DW),
   localparam int CW = DW + PW + 1
) (
   input  logic [CW-1:0] code_i,
   output logic [DW-1:0] data_o,
   output logic          corr_o,
   output logic          fatal_o
);

   logic [PW-1:0] syn;
   logic          ovr;
   logic [CW-1:0] fix;

   for (genvar p = 0; p < PW; p++) begin : g_syn
      assign syn[p] = ^(code_i & CW'(cover_mask(1 << p)));
   end

   assign ovr = ^code_i;

   for (genvar i = 0; i < CW; i++) begin : g_fix
      assign fix[i] = code_i[i] ^ (ovr && (syn == PW'(i)));
      if (is_data_pos(i)) begin : g_out
         assign data_o[data_idx(i)] = fix[i];
      end
   end

   // odd weight: one flip, located by the syndrome (0 means parity bit)
   // even weight with nonzero syndrome, or a syndrome past the word: two flips
   assign corr_o  = ovr && (syn <= PW'(CW - 1));
   assign fatal_o = (ovr && (syn > PW'(CW - 1))) || (!ovr && (syn != '0));

endmodule

// File: rtl/rsq_prog_mem.sv
module rsq_prog_mem #(
   parameter int BANKS = 2,
   parameter int DEPTH = 128,
   parameter int CW    = 13,
   localparam int AW   = $clog2(DEPTH),
   localparam int BW   = $clog2(BANKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [BW-1:0] wr_bank,
   input  logic [AW-1:0] wr_addr,
   input  logic [CW-1:0] wr_code,
   input  logic [BW-1:0] rd_bank,
   input  logic [AW-1:0] rd_addr,
   output logic [CW-1:0] rd_code
);

   logic [CW-1:0] bank_rd [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [CW-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
         end else if (we && (wr_bank == BW'(b))) begin
            mem[wr_addr] <= wr_code;
         end
      end

      assign bank_rd[b] = mem[rd_addr];
   end

   assign rd_code = bank_rd[rd_bank];

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
   import rsq_pkg::*;
#(
   parameter int DEPTH  = 128,
   parameter int STROBE = 4,
   parameter int ROW_W  = 7,
   parameter int BW     = 1,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = (STROBE > 1) ? $clog2(STROBE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [BW-1:0]    bank_req_i,
   input  logic             err_clr_i,
   input  logic [ROW_W:0]   dec_data_i,
   input  logic             dec_corr_i,
   input  logic             dec_fatal_i,
   output logic [BW-1:0]    bank_o,
   output logic [AW-1:0]    pc_o,
   output seq_state_t       st_o,
   output logic [ROW_W-1:0] row_o,
   output logic             corr_o,
   output logic             halt_o
);

   seq_state_t       st;
   logic [AW-1:0]    pc;
   logic [BW-1:0]    bank;
   logic [CNT_W-1:0] cnt;
   logic [ROW_W-1:0] row;
   logic             last;
   logic             corr;
   logic             win_done;
   logic             pass_end;

   assign win_done = (cnt == CNT_W'(STROBE - 1));
   assign pass_end = last || (pc == AW'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         pc   <= '0;
         bank <= '0;
         cnt  <= '0;
         row  <= '0;
         last <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (run_i) begin
                  pc   <= '0;
                  bank <= bank_req_i;
                  st   <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (dec_fatal_i) begin
                  st <= S_HALT;
               end else begin
                  row  <= dec_data_i[ROW_W-1:0];
                  last <= dec_data_i[ROW_W];
                  cnt  <= '0;
                  st   <= S_GATE;
               end
            end
            S_GATE: begin
               if (win_done) begin
                  cnt <= '0;
                  st  <= S_CLEAR;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_CLEAR: begin
               if (win_done) begin
                  cnt <= '0;
                  if (pass_end) begin
                     pc   <= '0;
                     bank <= bank_req_i;
                  end else begin
                     pc <= pc + 1'b1;
                  end
                  st <= run_i ? S_FETCH : S_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_HALT: begin
               if (err_clr_i) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr <= 1'b0;
      end else if (err_clr_i) begin
         corr <= 1'b0;
      end else if ((st == S_FETCH) && !dec_fatal_i && dec_corr_i) begin
         corr <= 1'b1;
      end
   end

   assign bank_o = bank;
   assign pc_o   = pc;
   assign st_o   = st;
   assign row_o  = row;
   assign corr_o = corr;
   assign halt_o = (st == S_HALT);

endmodule

// File: rtl/rsq_row_drive.sv
module rsq_row_drive
   import rsq_pkg::*;
#(
   parameter int ROWS    = 128,
   parameter int ROW_W   = 7,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_state_t       st_i,
   input  logic [ROW_W-1:0] row_i,
   output logic [ROWS-1:0]  gate_o,
   output logic [ROWS-1:0]  clear_o
);

   logic [ROWS-1:0] gate_n;
   logic [ROWS-1:0] clear_n;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign gate_n[r]  = (st_i == S_GATE)  && (row_i == ROW_W'(r));
      assign clear_n[r] = (st_i == S_CLEAR) && (row_i == ROW_W'(r));
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gate_o  <= '0;
            clear_o <= '0;
         end else begin
            gate_o  <= gate_n;
            clear_o <= clear_n;
         end
      end
   end else begin : g_comb
      assign gate_o  = gate_n;
      assign clear_o = clear_n;
   end

endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
   import rsq_pkg::*;
#(
   parameter int ROWS    = 128,
   parameter int DEPTH   = 128,
   parameter int BANKS   = 2,
   parameter int STROBE  = 4,
   parameter bit REG_OUT = 1'b1,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int DW     = ROW_W + 1,
   localparam int CW     = DW + ecc_par_bits(DW) + 1,
   localparam int AW     = $clog2(DEPTH),
   localparam int BW     = $clog2(BANKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [BW-1:0]   bank_req,
   input  logic            ld_we,
   input  logic [BW-1:0]   ld_bank,
   input  logic [AW-1:0]   ld_addr,
   input  logic [DW-1:0]   ld_data,
   input  logic [CW-1:0]   ld_flip,
   input  logic            err_clr,
   output logic [ROWS-1:0] gate_o,
   output logic [ROWS-1:0] clear_o,
   output logic [BW-1:0]   active_bank_o,
   output logic            corr_err_o,
   output logic            halt_o
);

   if (ROWS < 2) begin : g_bad_rows
      $error("row_seq_top: ROWS must be at least 2");
   end
   if ((BANKS < 2) || ((1 << BW) != BANKS)) begin : g_bad_banks
      $error("row_seq_top: BANKS must be a power of two, at least 2");
   end
   if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
      $error("row_seq_top: DEPTH must be a power of two, at least 2");
   end
   if (STROBE < 1) begin : g_bad_strobe
      $error("row_seq_top: STROBE must be at least 1");
   end

   logic [CW-1:0]    enc_code;
   logic [CW-1:0]    rd_code;
   logic [DW-1:0]    dec_data;
   logic             dec_corr;
   logic             dec_fatal;
   logic [BW-1:0]    cur_bank;
   logic [AW-1:0]    pc;
   seq_state_t       seq_st;
   logic [ROW_W-1:0] cur_row;

   rsq_ecc_enc #(.DW(DW)) u_enc (
      .data_i (ld_data),
      .code_o (enc_code)
   );

   rsq_prog_mem #(.BANKS(BANKS), .DEPTH(DEPTH), .CW(CW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ld_we),
      .wr_bank (ld_bank),
      .wr_addr (ld_addr),
      .wr_code (enc_code ^ ld_flip),
      .rd_bank (cur_bank),
      .rd_addr (pc),
      .rd_code (rd_code)
   );

   rsq_ecc_dec #(.DW(DW)) u_dec (
      .code_i  (rd_code),
      .data_o  (dec_data),
      .corr_o  (dec_corr),
      .fatal_o (dec_fatal)
   );

   rsq_ctrl #(.DEPTH(DEPTH), .STROBE(STROBE), .ROW_W(ROW_W), .BW(BW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .bank_req_i  (bank_req),
      .err_clr_i   (err_clr),
      .dec_data_i  (dec_data),
      .dec_corr_i  (dec_corr),
      .dec_fatal_i (dec_fatal),
      .bank_o      (cur_bank),
      .pc_o        (pc),
      .st_o        (seq_st),
      .row_o       (cur_row),
      .corr_o      (corr_err_o),
      .halt_o      (halt_o)
   );

   rsq_row_drive #(.ROWS(ROWS), .ROW_W(ROW_W), .REG_OUT(REG_OUT)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_i    (seq_st),
      .row_i   (cur_row),
      .gate_o  (gate_o),
      .clear_o (clear_o)
   );

   assign active_bank_o = cur_bank;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
   import rsq_pkg::*;
#(
   parameter int ROWS = 128,
   parameter int BW   = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            err_clr,
   input logic [ROWS-1:0] gate_o,
   input logic [ROWS-1:0] clear_o,
   input logic [BW-1:0]   active_bank_o,
   input logic            corr_err_o,
   input logic            halt_o,
   input seq_state_t      seq_st
);

   // R4: one row at a time, gate and clear exclusive
   a_r4_onehot_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_o));
   a_r4_onehot_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clear_o));
   a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      (|gate_o) |-> !(|clear_o));

   // R3: a clear window opens only straight after a gate window
   a_r3_clear_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|clear_o) |-> $past(|gate_o));

   // R5: the bank moves only at a pass boundary or on a start from idle
   a_r5_bank_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_bank_o) |-> ($past(seq_st) == S_IDLE || $past(seq_st) == S_CLEAR));

   // R7: correction flag is sticky
   a_r7_corr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_err_o && !err_clr) |=> corr_err_o);

   // R8: halted means quiet outputs, held until cleared
   a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> (gate_o == '0 && clear_o == '0));
   a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !err_clr) |=> halt_o);

endmodule

bind row_seq_top rsq_checker #(.ROWS(ROWS), .BW(BW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .err_clr       (err_clr),
   .gate_o        (gate_o),
   .clear_o       (clear_o),
   .active_bank_o (active_bank_o),
   .corr_err_o    (corr_err_o),
   .halt_o        (halt_o),
   .seq_st        (seq_st)
);

// File: tb/row_seq_top_test.sv
`timescale 1ns/1ps
module row_seq_top_test;

   localparam int ROWS = 128;
   localparam int S    = 3;
   localparam int CW   = 13;
   localparam int MAXE = 1024;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            run = 1'b0;
   logic            bank_req = 1'b0;
   logic            ld_we = 1'b0;
   logic            ld_bank = 1'b0;
   logic [6:0]      ld_addr = '0;
   logic [7:0]      ld_data = '0;
   logic [CW-1:0]   ld_flip = '0;
   logic            err_clr = 1'b0;
   logic [ROWS-1:0] gate_o;
   logic [ROWS-1:0] clear_o;
   logic            active_bank_o;
   logic            corr_err_o;
   logic            halt_o;

   row_seq_top #(.ROWS(ROWS), .DEPTH(128), .BANKS(2), .STROBE(S), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .bank_req(bank_req),
      .ld_we(ld_we), .ld_bank(ld_bank), .ld_addr(ld_addr), .ld_data(ld_data),
      .ld_flip(ld_flip), .err_clr(err_clr), .gate_o(gate_o), .clear_o(clear_o),
      .active_bank_o(active_bank_o), .corr_err_o(corr_err_o), .halt_o(halt_o)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // ---------------- output monitor ----------------
   int ev_n = 0;
   int ev_row  [MAXE];
   int ev_crow [MAXE];
   int ev_gw   [MAXE];
   int ev_cw   [MAXE];
   int ev_gap  [MAXE];
   int gcnt = 0, ccnt = 0, zcnt = 0, oh_bad = 0;

   always @(negedge clk) begin
      int gr, cr;
      gr = -1;
      cr = -1;
      for (int i = 0; i < ROWS; i++) begin
         if (gate_o[i])  gr = i;
         if (clear_o[i]) cr = i;
      end
      if ($countones(gate_o) > 1 || $countones(clear_o) > 1 || (gr >= 0 && cr >= 0)) oh_bad++;
      if (gr >= 0) begin
         if (gcnt == 0 && ev_n < MAXE) begin
            ev_row[ev_n] = gr;
            ev_gap[ev_n] = zcnt;
            ev_gw[ev_n]  = 0;
            ev_cw[ev_n]  = 0;
            ev_crow[ev_n] = -1;
            ev_n++;
         end
         gcnt++;
      end else if (gcnt > 0) begin
         if (ev_n > 0) ev_gw[ev_n-1] = gcnt;
         gcnt = 0;
      end
      if (cr >= 0) begin
         if (ccnt == 0 && ev_n > 0) ev_crow[ev_n-1] = cr;
         ccnt++;
      end else if (ccnt > 0) begin
         if (ev_n > 0) ev_cw[ev_n-1] = ccnt;
         ccnt = 0;
      end
      if (gr < 0 && cr < 0) zcnt++;
      else zcnt = 0;
   end

   // ---------------- helpers ----------------
   int exp_row [MAXE];
   int exp_n = 0;
   int roi [7] = '{20, 21, 22, 20, 21, 22, 99};

   task automatic chk(input bit ok, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", what, act, expv);
      end
   endtask

   task automatic push(input int v);
      exp_row[exp_n] = v;
      exp_n++;
   endtask

   task automatic push_roi();
      for (int i = 0; i < 7; i++) push(roi[i]);
   endtask

   task automatic wr(input bit b, input int a, input int d, input logic [CW-1:0] f);
      @(posedge clk); #1;
      ld_we = 1'b1; ld_bank = b; ld_addr = 7'(a); ld_data = 8'(d); ld_flip = f;
      @(posedge clk); #1;
      ld_we = 1'b0; ld_flip = '0;
   endtask

   task automatic pulse_clr();
      @(posedge clk); #1 err_clr = 1'b1;
      @(posedge clk); #1 err_clr = 1'b0;
   endtask

   task automatic stop_run();
      @(posedge clk); #1 run = 1'b0;
      repeat (2 * S + 6) @(negedge clk);
   endtask

   task automatic start_run();
      @(negedge clk);
      ev_n = 0;
      @(posedge clk); #1 run = 1'b1;
   endtask

   task automatic wait_events(input int n);
      int t;
      t = 0;
      while (ev_n < n && t < 4000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic collect(input int n);
      wait_events(n);
      repeat (2 * S + 3) @(negedge clk);
   endtask

   task automatic check_seq(input int n, input string tag);
      int bad_row, bad_w, bad_gap, fb;
      bad_row = 0; bad_w = 0; bad_gap = 0; fb = -1;
      chk(ev_n >= n, {tag, " R2 step count"}, ev_n, n);
      for (int k = 0; k < n && k < MAXE; k++) begin
         if (ev_row[k] != exp_row[k]) begin
            bad_row++;
            if (fb < 0) fb = k;
         end
         if (ev_gw[k] != S || ev_cw[k] != S || ev_crow[k] != ev_row[k]) bad_w++;
         if (k > 0 && ev_gap[k] != 1) bad_gap++;
      end
      if (fb < 0) chk(1'b1, {tag, " R2 row order"}, 0, 0);
      else chk(1'b0, {tag, " R2 row order (first bad step row)"}, ev_row[fb], exp_row[fb]);
      chk(bad_w == 0, {tag, " R3 gate/clear widths and row match"}, bad_w, 0);
      chk(bad_gap == 0, {tag, " R3 one idle cycle between steps"}, bad_gap, 0);
      chk(oh_bad == 0, {tag, " R4 one-hot exclusive lines"}, oh_bad, 0);
   endtask

   // ---------------- scenarios ----------------
   initial begin
      int dbl_bad;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R1: reset state and quiet while not running
      chk(gate_o == '0, "R1 gate lines low after reset", $countones(gate_o), 0);
      chk(clear_o == '0, "R1 clear lines low after reset", $countones(clear_o), 0);
      chk(!corr_err_o && !halt_o, "R1 flags low after reset", {corr_err_o, halt_o}, 0);
      chk(active_bank_o == 1'b0, "R1 bank 0 after reset", active_bank_o, 0);
      chk(ev_n == 0, "R1 no row driven while run low", ev_n, 0);

      // R6: load full scan in bank 0, region-of-interest program in bank 1
      for (int i = 0; i < 128; i++) wr(1'b0, i, (i == 127) ? (128 + i) : i, '0);
      for (int i = 0; i < 7; i++) wr(1'b1, i, (i == 6) ? (128 + roi[i]) : roi[i], '0);

      // R2/R3/R4: full pass on bank 0 and its wrap
      bank_req = 1'b0;
      start_run();
      collect(131);
      exp_n = 0;
      for (int i = 0; i < 128; i++) push(i);
      push(0); push(1); push(2);
      check_seq(131, "full scan");
      chk(!corr_err_o, "R7 clean program leaves flag low", corr_err_o, 0);

      // R9: stop mid pass, step finishes, then restart from entry 0
      stop_run();
      start_run();
      wait_events(10);
      @(posedge clk); #1 run = 1'b0;
      repeat (40) @(negedge clk);
      chk(ev_n == 10, "R9 no new step after run low", ev_n, 10);
      chk(ev_cw[9] == S, "R9 step in progress completes clear window", ev_cw[9], S);
      start_run();
      wait_events(5);
      chk(ev_row[0] == 0, "R9 restart at entry 0", ev_row[0], 0);

      // R5: bank request mid pass waits for the pass end
      @(posedge clk); #1 bank_req = 1'b1;
      repeat (3) @(negedge clk);
      chk(active_bank_o == 1'b0, "R5 bank held during pass", active_bank_o, 0);
      collect(136);
      exp_n = 0;
      for (int i = 0; i < 128; i++) push(i);
      push_roi();
      push(20);
      check_seq(136, "bank switch");
      chk(active_bank_o == 1'b1, "R5 bank 1 active after pass end", active_bank_o, 1);

      // R6/R2: region program repeats and skips
      stop_run();
      start_run();
      collect(15);
      exp_n = 0;
      push_roi(); push_roi(); push(20);
      check_seq(15, "R6 roi program");

      // R7: every single-bit flip of a stored entry is corrected
      for (int b = 0; b < CW; b++) begin
         stop_run();
         wr(1'b1, 1, 21, CW'(1) << b);
         pulse_clr();
         chk(!corr_err_o, "R7 flag cleared by err_clr", corr_err_o, 0);
         start_run();
         collect(3);
         exp_n = 0;
         push(20); push(21); push(22);
         check_seq(3, $sformatf("R7 single flip bit %0d", b));
         chk(corr_err_o, $sformatf("R7 flag set for flip bit %0d", b), corr_err_o, 1);
      end
      stop_run();
      repeat (50) @(negedge clk);
      chk(corr_err_o, "R7 flag sticky while idle", corr_err_o, 1);
      wr(1'b1, 1, 21, '0);
      pulse_clr();
      chk(!corr_err_o, "R7 flag low after clear", corr_err_o, 0);

      // R8: every two-bit flip halts at fetch
      dbl_bad = 0;
      for (int b1 = 0; b1 < CW; b1++) begin
         for (int b2 = b1 + 1; b2 < CW; b2++) begin
            @(posedge clk); #1 run = 1'b0;
            pulse_clr();
            wr(1'b1, 0, 20, (CW'(1) << b1) | (CW'(1) << b2));
            start_run();
            repeat (20) @(negedge clk);
            if (!(halt_o && ev_n == 0 && gate_o == '0 && clear_o == '0)) dbl_bad++;
         end
      end
      chk(dbl_bad == 0, "R8 all double flips halt with quiet outputs", dbl_bad, 0);
      @(posedge clk); #1 run = 1'b0;
      pulse_clr();
      chk(!halt_o, "R8 err_clr leaves halt", halt_o, 0);
      wr(1'b1, 0, 20, '0);

      // R8: halt in mid pass after two good steps
      wr(1'b1, 2, 22, 13'b0000000100100);
      start_run();
      repeat (60) @(negedge clk);
      chk(halt_o, "R8 halt on corrupted third entry", halt_o, 1);
      chk(ev_n == 2, "R8 steps before halt", ev_n, 2);
      chk(gate_o == '0 && clear_o == '0, "R8 outputs quiet in halt", $countones(gate_o | clear_o), 0);
      @(posedge clk); #1 run = 1'b0;
      pulse_clr();
      chk(!halt_o, "R8 halt released", halt_o, 0);
      wr(1'b1, 2, 22, '0);
      start_run();
      collect(7);
      exp_n = 0;
      push_roi();
      check_seq(7, "R8 recovered roi");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule